// File: doc/BRIEF.md
# Flash Status Flag and Command Gate

This block holds the status flags of a serial flash command engine and decides whether each decoded instruction is allowed to run. An upstream decoder presents one strobe bit per instruction. The gate answers in the same cycle with a per-instruction accept bit. Accepted instructions then update four flags on the next clock edge: the write-enable latch, busy, program-fail and erase-fail.

Busy can be raised in two ways. Array operations (page read, program, erase, one-time-programmable program and lock, bad-block remap, streaming read) keep busy high until the array sequencer returns a completion pulse, which may carry a failure indication. A program or erase that the protection lookup reports as forbidden sets its fail bit and holds busy for only a short fixed window. After a power-on reset, busy is held for a fixed start-up window. The flags are also packed into a read-back status byte with the unused bits forced to zero.

Top module: `flash_status_gate`

## Requirements
- R1: While `rst` is high and after it falls, `wel`, `prog_fail` and `erase_fail` are 0. `busy` is 1 and stays 1 until exactly PWRUP_CYCLES rising edges have passed since the first edge with `rst` low.
- R2: An accepted write-enable (strobe bit 0) sets `wel` on the next edge. An accepted write-disable (bit 1) clears it.
- R3: An accepted program-execute (bit 2), block-erase (bit 3), page-read (bit 4) or OTP-program (bit 5) clears `wel` on the next edge.
- R4: An accepted page-read (bit 4), OTP-lock (bit 6), bad-block remap (bit 7) or streaming read (bit 8) raises `busy` on the next edge. So does an unprotected program-execute, block-erase or OTP-program. Busy then stays high until an `op_done` pulse, and drops on the edge that samples it. An `op_done` while not waiting for completion has no effect on any flag.
- R5: While `busy` is 1, only read-status (bit 9) and read-ID (bit 10) are accepted. Every other strobe gets accept 0 and changes no flag.
- R6: Program-execute, block-erase and OTP-program are accepted only when `wel` is 1. When they are rejected, no flag changes.
- R7: When `op_done` arrives with `op_fail` high, `prog_fail` is set if the pending operation was a program-execute or OTP-program, and `erase_fail` is set if it was a block-erase. A passing completion, or the completion of any other operation, leaves both bits unchanged.
- R8: An accepted program-execute or OTP-program with `prot_hit` high sets `prog_fail`. An accepted block-erase with `prot_hit` high sets `erase_fail`. In both cases `busy` is 1 for exactly PROT_CYCLES edges and then clears without waiting for `op_done`.
- R9: Both fail bits are cleared when a program-execute or block-erase is accepted, before any protection result applies. Both are also cleared by an accepted device-reset (bit 11).
- R10: `status_byte` carries busy in bit 0, `wel` in bit 1, `erase_fail` in bit 2 and `prog_fail` in bit 3. Bits 7 to 4 always read 0.
- R11: `accept` is 0 whenever the strobe vector is not exactly one-hot. An instruction with no accept changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| instr_stb | input | 12 | One-hot decoded instruction strobes |
| prot_hit | input | 1 | Protection lookup reports the current program or erase as forbidden |
| op_done | input | 1 | Completion pulse from the array sequencer |
| op_fail | input | 1 | Failure indication qualified by op_done |
| accept | output | 12 | Per-instruction accept, combinational from the strobe |
| busy | output | 1 | Operation in progress |
| wel | output | 1 | Write-enable latch |
| prog_fail | output | 1 | Program failure flag |
| erase_fail | output | 1 | Erase failure flag |
| status_byte | output | 8 | Packed read-back status |

## Verification
`accept` is combinational, so it is due in the same cycle as the strobe. Every flag and the status byte change on the first rising edge that samples an accepted strobe or an `op_done`. Busy windows from reset and protection hits last an exact count of edges. The bench drives inputs on the falling edge and checks `accept` shortly after. It then advances one rising edge, updates its own model of the flags, and compares all outputs at the next falling edge, so every result is checked in the cycle it is due. The busy windows are checked edge by edge against the model's down-counter.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

    localparam int NUM_INSTR = 12;

    // strobe bit positions (fixed: upstream decoder and status readers rely on them)
    localparam int IX_WR_EN      = 0;
    localparam int IX_WR_DIS     = 1;
    localparam int IX_PROG_EXEC  = 2;
    localparam int IX_BLK_ERASE  = 3;
    localparam int IX_PAGE_READ  = 4;
    localparam int IX_OTP_PROG   = 5;
    localparam int IX_OTP_LOCK   = 6;
    localparam int IX_BBM_REMAP  = 7;
    localparam int IX_CONT_READ  = 8;
    localparam int IX_RD_STATUS  = 9;
    localparam int IX_RD_ID      = 10;
    localparam int IX_DEV_RESET  = 11;

    typedef logic [NUM_INSTR-1:0] instr_vec_t;

    typedef enum logic [1:0] {
        BSY_IDLE  = 2'd0,
        BSY_TIMED = 2'd1,
        BSY_WAIT  = 2'd2
    } busy_mode_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_PROG  = 2'd1,
        KIND_ERASE = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic wel_set;
        logic wel_clr;
        logic fail_clr;
        logic set_pfail;
        logic set_efail;
    } flag_act_t;

    typedef struct packed {
        logic     start_wait;
        logic     start_timed;
        op_kind_e kind;
    } busy_act_t;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       pfail;
        logic       efail;
        logic       wel;
        logic       busy;
    } status_t;

    // instructions allowed through while busy
    function automatic instr_vec_t bypass_mask();
        instr_vec_t m = '0;
        m[IX_RD_STATUS] = 1'b1;
        m[IX_RD_ID]     = 1'b1;
        return m;
    endfunction

    // instructions that require the write-enable latch
    function automatic instr_vec_t wel_req_mask();
        instr_vec_t m = '0;
        m[IX_PROG_EXEC] = 1'b1;
        m[IX_BLK_ERASE] = 1'b1;
        m[IX_OTP_PROG]  = 1'b1;
        return m;
    endfunction

    function automatic logic is_single_hot(input instr_vec_t v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fg_cmd_gate.sv
module fg_cmd_gate
    import flash_gate_pkg::*;
(
    input  instr_vec_t instr_stb,
    input  logic       busy,
    input  logic       wel,
    input  logic       prot_hit,
    output instr_vec_t accept,
    output flag_act_t  flag_act,
    output busy_act_t  busy_act
);

    localparam instr_vec_t BYPASS = bypass_mask();
    localparam instr_vec_t NEEDWL = wel_req_mask();

    logic single;
    assign single = is_single_hot(instr_stb);

    for (genvar i = 0; i < NUM_INSTR; i++) begin : g_acc
        logic busy_ok;
        logic wel_ok;
        assign busy_ok   = !busy || BYPASS[i];
        assign wel_ok    = !NEEDWL[i] || wel;
        assign accept[i] = instr_stb[i] && single && busy_ok && wel_ok;
    end

    logic prog_like;
    logic erase_like;
    logic array_wait;
    assign prog_like  = accept[IX_PROG_EXEC] || accept[IX_OTP_PROG];
    assign erase_like = accept[IX_BLK_ERASE];
    assign array_wait = accept[IX_PAGE_READ] || accept[IX_OTP_LOCK]
                     || accept[IX_BBM_REMAP] || accept[IX_CONT_READ];

    always_comb begin
        flag_act           = '0;
        flag_act.wel_set   = accept[IX_WR_EN];
        flag_act.wel_clr   = accept[IX_WR_DIS] || accept[IX_PAGE_READ]
                          || prog_like || erase_like;
        flag_act.fail_clr  = prog_like || erase_like || accept[IX_DEV_RESET];
        flag_act.set_pfail = prog_like && prot_hit;
        flag_act.set_efail = erase_like && prot_hit;
    end

    always_comb begin
        busy_act             = '0;
        busy_act.start_timed = (prog_like || erase_like) && prot_hit;
        busy_act.start_wait  = ((prog_like || erase_like) && !prot_hit) || array_wait;
        if (prog_like)       busy_act.kind = KIND_PROG;
        else if (erase_like) busy_act.kind = KIND_ERASE;
        else                 busy_act.kind = KIND_NONE;
    end

endmodule

// File: rtl/fg_busy_ctrl.sv
module fg_busy_ctrl
    import flash_gate_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 8,
    parameter int unsigned PROT_CYCLES  = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  busy_act_t busy_act,
    input  logic      op_done,
    input  logic      op_fail,
    output logic      busy,
    output logic      done_pfail,
    output logic      done_efail
);

    localparam int unsigned MAXC = max_u(PWRUP_CYCLES, PROT_CYCLES);
    localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] PWRUP_LOAD = CW'(PWRUP_CYCLES - 1);
    localparam logic [CW-1:0] PROT_LOAD  = CW'(PROT_CYCLES - 1);

    busy_mode_e      mode_q;
    op_kind_e        kind_q;
    logic [CW-1:0]   cnt_q;
    logic            finish;

    assign finish = (mode_q == BSY_WAIT) && op_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= BSY_TIMED;
            kind_q <= KIND_NONE;
            cnt_q  <= PWRUP_LOAD;
        end else begin
            unique case (mode_q)
                BSY_IDLE: begin
                    if (busy_act.start_timed) begin
                        mode_q <= BSY_TIMED;
                        cnt_q  <= PROT_LOAD;
                        kind_q <= KIND_NONE;
                    end else if (busy_act.start_wait) begin
                        mode_q <= BSY_WAIT;
                        kind_q <= busy_act.kind;
                    end
                end
                BSY_TIMED: begin
                    if (cnt_q == '0) mode_q <= BSY_IDLE;
                    else             cnt_q  <= cnt_q - 1'b1;
                end
                BSY_WAIT: begin
                    if (op_done) begin
                        mode_q <= BSY_IDLE;
                        kind_q <= KIND_NONE;
                    end
                end
                default: mode_q <= BSY_IDLE;
            endcase
        end
    end

    assign busy       = (mode_q != BSY_IDLE);
    assign done_pfail = finish && op_fail && (kind_q == KIND_PROG);
    assign done_efail = finish && op_fail && (kind_q == KIND_ERASE);

endmodule

// File: rtl/fg_flag_regs.sv
module fg_flag_regs
    import flash_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_act_t flag_act,
    input  logic      done_pfail,
    input  logic      done_efail,
    output logic      wel,
    output logic      prog_fail,
    output logic      erase_fail
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel <= 1'b0;
        end else if (flag_act.wel_set) begin
            wel <= 1'b1;
        end else if (flag_act.wel_clr) begin
            wel <= 1'b0;
        end
    end

    // clear at operation start, protection result applied after (set wins)
    always_ff @(posedge clk) begin
        if (rst) begin
            prog_fail  <= 1'b0;
            erase_fail <= 1'b0;
        end else begin
            if (flag_act.fail_clr) begin
                prog_fail  <= 1'b0;
                erase_fail <= 1'b0;
            end
            if (flag_act.set_pfail || done_pfail) prog_fail  <= 1'b1;
            if (flag_act.set_efail || done_efail) erase_fail <= 1'b1;
        end
    end

endmodule

// File: rtl/flash_status_gate.sv
module flash_status_gate
    import flash_gate_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 8,
    parameter int unsigned PROT_CYCLES  = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] instr_stb,
    input  logic        prot_hit,
    input  logic        op_done,
    input  logic        op_fail,
    output logic [11:0] accept,
    output logic        busy,
    output logic        wel,
    output logic        prog_fail,
    output logic        erase_fail,
    output logic [7:0]  status_byte
);

    flag_act_t flag_act;
    busy_act_t busy_act;
    logic      done_pfail;
    logic      done_efail;
    status_t   stat;

    fg_cmd_gate u_gate (
        .instr_stb (instr_stb),
        .busy      (busy),
        .wel       (wel),
        .prot_hit  (prot_hit),
        .accept    (accept),
        .flag_act  (flag_act),
        .busy_act  (busy_act)
    );

    fg_busy_ctrl #(
        .PWRUP_CYCLES (PWRUP_CYCLES),
        .PROT_CYCLES  (PROT_CYCLES)
    ) u_busy (
        .clk        (clk),
        .rst        (rst),
        .busy_act   (busy_act),
        .op_done    (op_done),
        .op_fail    (op_fail),
        .busy       (busy),
        .done_pfail (done_pfail),
        .done_efail (done_efail)
    );

    fg_flag_regs u_flags (
        .clk        (clk),
        .rst        (rst),
        .flag_act   (flag_act),
        .done_pfail (done_pfail),
        .done_efail (done_efail),
        .wel        (wel),
        .prog_fail  (prog_fail),
        .erase_fail (erase_fail)
    );

    always_comb begin
        stat       = '0;
        stat.busy  = busy;
        stat.wel   = wel;
        stat.efail = erase_fail;
        stat.pfail = prog_fail;
    end

    assign status_byte = stat;

endmodule

// File: rtl/flash_status_gate_chk.sv
module flash_status_gate_chk
    import flash_gate_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [11:0] instr_stb,
    input logic        prot_hit,
    input logic        op_done,
    input logic [11:0] accept,
    input logic        busy,
    input logic        wel,
    input logic        prog_fail,
    input logic        erase_fail,
    input logic [7:0]  status_byte
);

    logic other_stb;
    assign other_stb = |(instr_stb & ~bypass_mask());

    AST_BUSY_GATE: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((accept & ~bypass_mask()) == '0)); // R5

    AST_ACCEPT_SUBSET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(accept) && ((accept & ~instr_stb) == '0)); // R11

    AST_WEL_SET: assert property (@(posedge clk) disable iff (rst)
        accept[IX_WR_EN] |=> wel); // R2

    AST_WEL_CLR: assert property (@(posedge clk) disable iff (rst)
        (accept[IX_PROG_EXEC] || accept[IX_BLK_ERASE] || accept[IX_PAGE_READ] || accept[IX_OTP_PROG])
        |=> !wel); // R3

    AST_WAIT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (accept[IX_PAGE_READ] || accept[IX_OTP_LOCK] || accept[IX_BBM_REMAP] || accept[IX_CONT_READ])
        |=> busy); // R4

    AST_NO_WEL_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        !wel |-> !(accept[IX_PROG_EXEC] || accept[IX_BLK_ERASE] || accept[IX_OTP_PROG])); // R6

    AST_PROT_PFAIL: assert property (@(posedge clk) disable iff (rst)
        ((accept[IX_PROG_EXEC] || accept[IX_OTP_PROG]) && prot_hit) |=> (prog_fail && !erase_fail && busy)); // R8

    AST_PROT_EFAIL: assert property (@(posedge clk) disable iff (rst)
        (accept[IX_BLK_ERASE] && prot_hit) |=> (erase_fail && !prog_fail && busy)); // R8

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((accept[IX_PROG_EXEC] || accept[IX_BLK_ERASE] || accept[IX_DEV_RESET]) && !prot_hit)
        |=> (!prog_fail && !erase_fail)); // R9

    AST_REJECT_STILL: assert property (@(posedge clk) disable iff (rst)
        (other_stb && (accept == '0) && !op_done)
        |=> ($stable(wel) && $stable(prog_fail) && $stable(erase_fail))); // R11

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status_byte[7:4] == 4'b0000); // R10

    AST_IDLE_DONE: assert property (@(posedge clk) disable iff (rst)
        (!busy && op_done && (instr_stb == '0)) |=> ($stable(prog_fail) && $stable(erase_fail) && !busy)); // R4

endmodule

bind flash_status_gate flash_status_gate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_stb   (instr_stb),
    .prot_hit    (prot_hit),
    .op_done     (op_done),
    .accept      (accept),
    .busy        (busy),
    .wel         (wel),
    .prog_fail   (prog_fail),
    .erase_fail  (erase_fail),
    .status_byte (status_byte)
);

// File: tb/flash_status_gate_bench.sv
module flash_status_gate_bench;

    localparam int PWRUP = 8;
    localparam int PROT  = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] instr_stb;
    logic        prot_hit;
    logic        op_done;
    logic        op_fail;
    logic [11:0] accept;
    logic        busy;
    logic        wel;
    logic        prog_fail;
    logic        erase_fail;
    logic [7:0]  status_byte;

    int n_checks = 0;
    int n_fails  = 0;

    // bench model of the flags
    int m_mode;   // 0 idle, 1 timed, 2 waiting for done
    int m_cnt;
    int m_kind;   // 0 none, 1 program, 2 erase
    bit m_wel, m_pf, m_ef;

    always #2 clk = ~clk;

    flash_status_gate #(.PWRUP_CYCLES(PWRUP), .PROT_CYCLES(PROT)) u_flash_status_gate (
        .clk(clk), .rst(rst), .instr_stb(instr_stb), .prot_hit(prot_hit),
        .op_done(op_done), .op_fail(op_fail), .accept(accept), .busy(busy),
        .wel(wel), .prog_fail(prog_fail), .erase_fail(erase_fail),
        .status_byte(status_byte)
    );

    task automatic check(string tag, string what, logic [11:0] act, logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [11:0] oh(int i);
        return 12'(1) << i;
    endfunction

    function automatic logic [11:0] exp_accept(logic [11:0] v);
        logic [11:0] r = '0;
        if ($countones(v) != 1) return r;
        for (int i = 0; i < 12; i++) begin
            if (v[i]) begin
                bit ok = (m_mode == 0) || (i == 9) || (i == 10);
                if ((i == 2 || i == 3 || i == 5) && !m_wel) ok = 0;
                r[i] = ok;
            end
        end
        return r;
    endfunction

    task automatic check_flags(string tag);
        check(tag, "flags {busy,wel,pf,ef}", {8'h0, busy, wel, prog_fail, erase_fail},
              {8'h0, (m_mode != 0), m_wel, m_pf, m_ef});
        check("R10", "status_byte", {4'h0, status_byte},
              {4'h0, 4'h0, m_pf, m_ef, m_wel, (m_mode != 0)});
    endtask

    // drive at negedge, check accept, advance one edge, update model, check flags
    task automatic step(logic [11:0] v, bit p, bit d, bit f, string tag);
        logic [11:0] ea;
        int old;
        instr_stb = v; prot_hit = p; op_done = d; op_fail = f;
        ea = exp_accept(v);
        #1;
        check(tag, "accept", accept, ea);
        @(posedge clk);
        old = m_mode;
        if (old == 1) begin
            if (m_cnt == 0) m_mode = 0; else m_cnt--;
        end else if (old == 2 && d) begin
            if (f && m_kind == 1) m_pf = 1;
            if (f && m_kind == 2) m_ef = 1;
            m_mode = 0; m_kind = 0;
        end
        for (int i = 0; i < 12; i++) begin
            if (ea[i]) begin
                case (i)
                    0: m_wel = 1;
                    1: m_wel = 0;
                    2, 3, 5: begin
                        m_wel = 0; m_pf = 0; m_ef = 0;
                        if (p) begin
                            if (i == 3) m_ef = 1; else m_pf = 1;
                            m_mode = 1; m_cnt = PROT - 1;
                        end else begin
                            m_mode = 2; m_kind = (i == 3) ? 2 : 1;
                        end
                    end
                    4: begin m_wel = 0; m_mode = 2; m_kind = 0; end
                    6, 7, 8: begin m_mode = 2; m_kind = 0; end
                    11: begin m_pf = 0; m_ef = 0; end
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        instr_stb = '0; prot_hit = 0; op_done = 0; op_fail = 0;
        check_flags(tag);
    endtask

    function automatic string tag_of(int i);
        case (i)
            0, 1:    return "R2";
            2, 3, 5: return "R6";
            4:       return "R3";
            6, 7, 8: return "R4";
            9, 10:   return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1; instr_stb = '0; prot_hit = 0; op_done = 0; op_fail = 0;
        repeat (3) @(negedge clk);
        m_mode = 1; m_cnt = PWRUP - 1; m_kind = 0; m_wel = 0; m_pf = 0; m_ef = 0;
        check_flags("R1");
        rst = 0;
        // R1: power-up busy window, edge by edge; strobes rejected meanwhile
        step(oh(0), 0, 0, 0, "R1");
        while (m_mode != 0) step('0, 0, 0, 0, "R1");

        // R4: completion while idle changes nothing
        step('0, 0, 1, 1, "R4");
        // R11: multi-hot strobes rejected with no flag change
        step(oh(0) | oh(9), 0, 0, 0, "R11");
        step(12'hfff, 0, 0, 0, "R11");

        // near-exhaustive sweep: instruction x latch state x protection
        for (int idx = 0; idx < 12; idx++) begin
            for (int w = 0; w < 2; w++) begin
                for (int p = 0; p < 2; p++) begin
                    step(w ? oh(0) : oh(1), 0, 0, 0, "R2");
                    step(oh(idx), p[0], 0, 0, tag_of(idx));
                    if (m_mode == 2) begin
                        for (int j = 0; j < 12; j++) step(oh(j), 0, 0, 0, "R5");
                        step('0, 0, 1, ((idx + w) % 2) == 0, "R7");
                    end
                    if (m_mode == 1) step(oh(1), 0, 0, 0, "R5");
                    while (m_mode != 0) step('0, 0, 0, 0, "R8");
                end
            end
        end

        // R9: device reset clears a fail set by a protection hit
        step(oh(0), 0, 0, 0, "R2");
        step(oh(3), 1, 0, 0, "R8");
        while (m_mode != 0) step('0, 0, 0, 0, "R8");
        step(oh(11), 0, 0, 0, "R9");
        // R9: unprotected program clears an earlier erase fail at start
        step(oh(0), 0, 0, 0, "R2");
        step(oh(3), 1, 0, 0, "R8");
        while (m_mode != 0) step('0, 0, 0, 0, "R8");
        step(oh(0), 0, 0, 0, "R2");
        step(oh(2), 0, 0, 0, "R9");
        step('0, 0, 1, 0, "R7");
        // R7: completion of a non-program operation ignores op_fail
        step(oh(6), 0, 0, 0, "R4");
        step('0, 0, 1, 1, "R7");

        finish_run();
    end

endmodule